// File: doc/BRIEF.md
# Partitioned Two-Level Cluster Input Crossbar

This block is the input interconnect of a logic cluster. It takes a vector of cluster input signals and delivers them to the input pins of several small lookup tables. Signals pass through two levels of multiplexers. The first level is split into one partition per lookup table. Each first-level multiplexer reaches only a fixed sparse subset of the cluster inputs. Inside a partition, every second-level multiplexer can pick any first-level output of the same partition. No signal crosses from one partition to another, so the fabric is a set of disjoint sparse-then-full sub-crossbars.

Every multiplexer select is held in one configuration register, which is loaded serially one bit per clock. While loading is under way, all lookup-table pins are held at 0. Once loading ends, the path from the cluster inputs to the pins is purely combinational. A select value beyond a multiplexer's fan-in produces 0. It also raises an error flag that stays set until the next load begins.

Top module: `cluster_xbar`

## Requirements
- R1: There are NLUT*KIN output pins. Pin index p*KIN+k is input k of lookup table p, and it belongs to partition p.
- R2: Partition p holds L1W first-level multiplexers, each with fan-in FCIN. Let q = p*L1W+m and STEP = NIN/FCIN. Select value s (0..FCIN-1) of first-level multiplexer m picks cluster input (q + s*STEP) mod NIN.
- R3: Second-level multiplexer (p,k) is fully populated within its partition. Select value j (0..L1W-1) picks first-level output m=j of partition p.
- R4: Pins of partition p depend only on the cluster inputs reachable through the first-level multiplexers of partition p.
- R5: Each clock edge with cfgLoad high shifts cfgBit into bit 0 of the configuration word, and earlier bits move toward the MSB. First-level select q sits in bits [q*SEL1W +: SEL1W]. Second-level select r = p*KIN+k sits in bits [NLUT*L1W*SEL1W + r*SEL2W +: SEL2W].
- R6: While cfgLoad is high, every output pin is 0.
- R7: A first-level select of FCIN or more, or a second-level select of L1W or more, drives 0 on that multiplexer's output.
- R8: cfgErr is cleared on every clock edge where cfgLoad is high. On an edge where cfgLoad is low, it is set if any select is out of range. Once set, it holds until the next edge with cfgLoad high.
- R9: After reset, the configuration word is zero, cfgErr is 0, and pin p*KIN+k equals cluster input p*L1W.
- R10: With cfgLoad low, a change on clusterIn reaches the pins without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and the error flag |
| rstN | input | 1 | Active-low synchronous reset |
| clusterIn | input | NIN | Cluster input signals |
| cfgLoad | input | 1 | Shift enable for the configuration chain; blanks the outputs |
| cfgBit | input | 1 | Serial configuration data |
| lutPins | output | NLUT*KIN | Lookup-table input pins |
| cfgErr | output | 1 | Sticky out-of-range select flag |

## Verification
The hardest case to reach from the ports is the interaction of the two levels. The value on a pin depends on a second-level select and on the first-level select it points to. An out-of-range value at either level must produce 0 and must also set the error flag. The bench shifts in many pseudo-random configuration words, plus two directed ones: all zeros and all ones. The random words land on every mix of valid and out-of-range fields at both levels. For each word, the bench sweeps all cluster input patterns and compares every pin against a value computed from the source-index formula. This sweep also shows that no pin follows an input outside its own partition.

// File: rtl/cluster_xbar_pkg.sv
package cluster_xbar_pkg;
  // Strobes from the configuration control to the datapath
  typedef struct packed {
    logic blank;
  } xbarStrobe_t;
endpackage

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
  import cluster_xbar_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic          cfgBit,
  input  logic          selBad,
  output logic [CW-1:0] cfgWord,
  output xbarStrobe_t   strobe,
  output logic          cfgErr
);
  // Serial configuration chain, new bit enters at the LSB
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWord <= '0;
    end else if (cfgLoad) begin
      cfgWord <= {cfgWord[CW-2:0], cfgBit};
    end
  end

  // Sticky error, cleared while a load is in progress
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
    end else if (cfgLoad) begin
      cfgErr <= 1'b0;
    end else if (selBad) begin
      cfgErr <= 1'b1;
    end
  end

  always_comb begin
    strobe.blank = cfgLoad;
  end
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import cluster_xbar_pkg::*;
#(
  parameter int NIN   = 8,
  parameter int NLUT  = 2,
  parameter int KIN   = 2,
  parameter int L1W   = 3,
  parameter int FCIN  = 3,
  parameter int SEL1W = 2,
  parameter int SEL2W = 2,
  parameter int CW    = 20
) (
  input  logic [NIN-1:0]      clusterIn,
  input  logic [CW-1:0]       cfgWord,
  input  xbarStrobe_t         strobe,
  output logic [NLUT*KIN-1:0] lutPins,
  output logic                selBad
);
  localparam int NL1    = NLUT * L1W;
  localparam int NPIN   = NLUT * KIN;
  localparam int STEP   = (NIN / FCIN) > 0 ? (NIN / FCIN) : 1;
  localparam int L1BITS = NL1 * SEL1W;

  function automatic int srcIdx(int q, int s);
    return (q + s * STEP) % NIN;
  endfunction

  logic [NL1-1:0]  l1Flat;
  logic [NL1-1:0]  bad1;
  logic [NPIN-1:0] bad2;

  // First level: sparse, one group of L1W muxes per partition
  for (genvar p = 0; p < NLUT; p++) begin : g_part
    for (genvar m = 0; m < L1W; m++) begin : g_l1
      localparam int Q = p * L1W + m;
      logic [SEL1W-1:0] sel1;
      logic             pick1;
      logic             miss1;
      assign sel1 = cfgWord[Q*SEL1W +: SEL1W];
      always_comb begin
        pick1 = 1'b0;
        miss1 = 1'b1;
        for (int s = 0; s < FCIN; s++) begin
          if (sel1 == SEL1W'(s)) begin
            pick1 = clusterIn[srcIdx(Q, s)];
            miss1 = 1'b0;
          end
        end
      end
      assign l1Flat[Q] = pick1;
      assign bad1[Q]   = miss1;
    end

    // Second level: full within the partition
    for (genvar k = 0; k < KIN; k++) begin : g_l2
      localparam int R = p * KIN + k;
      logic [SEL2W-1:0] sel2;
      logic             pick2;
      logic             miss2;
      assign sel2 = cfgWord[L1BITS + R*SEL2W +: SEL2W];
      always_comb begin
        pick2 = 1'b0;
        miss2 = 1'b1;
        for (int j = 0; j < L1W; j++) begin
          if (sel2 == SEL2W'(j)) begin
            pick2 = l1Flat[p*L1W + j];
            miss2 = 1'b0;
          end
        end
      end
      assign bad2[R]    = miss2;
      assign lutPins[R] = strobe.blank ? 1'b0 : pick2;
    end
  end

  assign selBad = (|bad1) | (|bad2);
endmodule

// File: rtl/cluster_xbar.sv
module cluster_xbar
  import cluster_xbar_pkg::*;
#(
  parameter int NIN  = 8,
  parameter int NLUT = 2,
  parameter int KIN  = 2,
  parameter int L1W  = 3,
  parameter int FCIN = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NIN-1:0]      clusterIn,
  input  logic                cfgLoad,
  input  logic                cfgBit,
  output logic [NLUT*KIN-1:0] lutPins,
  output logic                cfgErr
);
  localparam int SEL1W = (FCIN > 1) ? $clog2(FCIN) : 1;
  localparam int SEL2W = (L1W > 1) ? $clog2(L1W) : 1;
  localparam int CW    = NLUT * L1W * SEL1W + NLUT * KIN * SEL2W;

  logic [CW-1:0] cfgWord;
  xbarStrobe_t   strobe;
  logic          selBad;

  xbar_cfg_ctrl #(.CW(CW)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgBit(cfgBit),
    .selBad(selBad), .cfgWord(cfgWord), .strobe(strobe), .cfgErr(cfgErr)
  );

  xbar_datapath #(
    .NIN(NIN), .NLUT(NLUT), .KIN(KIN), .L1W(L1W), .FCIN(FCIN),
    .SEL1W(SEL1W), .SEL2W(SEL2W), .CW(CW)
  ) i_dp (
    .clusterIn(clusterIn), .cfgWord(cfgWord), .strobe(strobe),
    .lutPins(lutPins), .selBad(selBad)
  );
endmodule

// File: rtl/cluster_xbar_checker.sv
module cluster_xbar_checker #(
  parameter int NIN  = 8,
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [NIN-1:0]  clusterIn,
  input logic            cfgLoad,
  input logic [NPIN-1:0] lutPins,
  input logic            cfgErr
);
  p_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |-> lutPins == '0);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !cfgErr);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !cfgLoad) |=> cfgErr);

  p_err_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> $past(!cfgLoad));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoad && $past(!cfgLoad) && $stable(clusterIn)) |-> $stable(lutPins));
endmodule

bind cluster_xbar cluster_xbar_checker #(.NIN(NIN), .NPIN(NLUT*KIN)) i_chk (
  .clk(clk), .rstN(rstN), .clusterIn(clusterIn), .cfgLoad(cfgLoad),
  .lutPins(lutPins), .cfgErr(cfgErr)
);

// File: tb/test_cluster_xbar.sv
`timescale 1ns/1ps
module test_cluster_xbar;
  localparam int NIN = 8, NLUT = 2, KIN = 2, L1W = 3, FCIN = 3;
  localparam int SEL1W = 2, SEL2W = 2, STEP = NIN / FCIN;
  localparam int L1BITS = NLUT * L1W * SEL1W;
  localparam int CW = L1BITS + NLUT * KIN * SEL2W;
  localparam int NPIN = NLUT * KIN;

  logic clk = 0, rstN = 0, cfgLoad = 0, cfgBit = 0;
  logic [NIN-1:0] clusterIn = '0;
  logic [NPIN-1:0] lutPins;
  logic cfgErr;
  int nChecks = 0, nFails = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  cluster_xbar i_cluster_xbar (
    .clk(clk), .rstN(rstN), .clusterIn(clusterIn), .cfgLoad(cfgLoad),
    .cfgBit(cfgBit), .lutPins(lutPins), .cfgErr(cfgErr)
  );

  task automatic check(input string tag, input int idx, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s item %0d: got %b expected %b", tag, idx, act, exp);
    end
  endtask

  // Expected pin value from the select layout and source formula
  function automatic logic expPin(int r, logic [CW-1:0] w, logic [NIN-1:0] x);
    int p, s2, q, s1;
    p  = r / KIN;
    s2 = int'((w >> (L1BITS + r*SEL2W)) & 3);
    if (s2 >= L1W) return 1'b0;
    q  = p * L1W + s2;
    s1 = int'((w >> (q*SEL1W)) & 3);
    if (s1 >= FCIN) return 1'b0;
    return x[(q + s1*STEP) % NIN];
  endfunction

  function automatic logic expBad(logic [CW-1:0] w);
    logic b;
    b = 1'b0;
    for (int q = 0; q < NLUT*L1W; q++)
      if (int'((w >> (q*SEL1W)) & 3) >= FCIN) b = 1'b1;
    for (int r = 0; r < NPIN; r++)
      if (int'((w >> (L1BITS + r*SEL2W)) & 3) >= L1W) b = 1'b1;
    return b;
  endfunction

  function automatic string tagFor(int r, logic [CW-1:0] w);
    int s2, q;
    s2 = int'((w >> (L1BITS + r*SEL2W)) & 3);
    if (s2 >= L1W) return "R7";
    q = (r / KIN) * L1W + s2;
    if (int'((w >> (q*SEL1W)) & 3) >= FCIN) return "R7";
    return "R1 R2 R3 R4 R5 R10";
  endfunction

  task automatic loadCfg(input logic [CW-1:0] w);
    for (int b = CW - 1; b >= 0; b--) begin
      @(negedge clk);
      cfgLoad = 1'b1;
      cfgBit  = w[b];
      clusterIn = NIN'(b * 37 + 5);
      #2;
      for (int r = 0; r < NPIN; r++) check("R6", r, lutPins[r], 1'b0);
    end
    @(negedge clk);
    cfgLoad = 1'b0;
    #1;
    check("R8 clear", 0, cfgErr, 1'b0);
    @(negedge clk);
    #1;
    check("R8 set", 0, cfgErr, expBad(w));
  endtask

  task automatic sweep(input logic [CW-1:0] w);
    for (int x = 0; x < (1 << NIN); x++) begin
      clusterIn = NIN'(x);
      #1;
      for (int r = 0; r < NPIN; r++) check(tagFor(r, w), r, lutPins[r], expPin(r, w, NIN'(x)));
    end
    @(negedge clk);
    #1;
    check("R8 sticky", 1, cfgErr, expBad(w));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [CW-1:0] w;
    clusterIn = 8'b1011_0101;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: reset state routes input p*L1W to every pin of partition p
    check("R9 err", 0, cfgErr, 1'b0);
    for (int r = 0; r < NPIN; r++) check("R9", r, lutPins[r], clusterIn[(r / KIN) * L1W]);
    sweep('0);

    loadCfg({CW{1'b1}});
    sweep({CW{1'b1}});

    // Valid first level, one second-level select out of range
    w = '0;
    w[L1BITS +: SEL2W] = 2'd3;
    w[0 +: SEL1W] = 2'd2;
    w[SEL1W*4 +: SEL1W] = 2'd1;
    loadCfg(w);
    sweep(w);

    for (int t = 0; t < 40; t++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      w = lcg[31:12];
      loadCfg(w);
      sweep(w);
    end
    finishRun();
  end
endmodule